// File: doc/BRIEF.md
# Operating System Tick Timer

This block is a periodic down counter that paces an operating system scheduler. Software programs a reload value and turns the counter on. The counter then counts down to zero, reloads by itself, and counts down again. Each time the count steps from one to zero, a sticky event flag is set. The flag drives the interrupt line unless the interrupt is masked. The same block can also serve as a plain periodic down counter with the interrupt masked.

Each decrement happens on an "active tick". Ticks come either from every core clock cycle or from a one-in-eight clock enable made by an internal prescaler, so the whole block runs in one clock domain. Software reaches the block through a small register port with a combinational read path. There are three registers:

- control/status at address 0;
- reload at address 1;
- current value at address 2.

Address 3 reads as zero.

Top module: `os_tick_timer`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low.
- R2: The counter is 24 bits wide. The reload register keeps bits 23:0 of a write, and bits 31:24 read as zero. On each active tick a non-zero count decreases by exactly one.
- R3: On an active tick with the count at zero, the counter loads the reload value. A full period is therefore reload+1 active ticks.
- R4: Control bit 16 is the event flag. It sets on the active tick that takes the count from 1 to 0. `irq` equals the flag gated by control bit 1 (interrupt enable), so with bit 1 at 0 the flag still sets but `irq` stays low.
- R5: A read of the control/status register (address 0) clears the event flag on that cycle's clock edge. If a new 1-to-0 step happens on the same edge, the flag stays set.
- R6: A write of any value to the current-value register (address 2) sets the count to zero and clears the event flag. This write takes precedence over an active tick on the same edge.
- R7: With a reload value of zero, the counter stays at zero and the event flag never sets.
- R8: Control bit 2 selects the tick source. With bit 2 at 1, every cycle is active. With bit 2 at 0, one cycle in eight is active. The prescaler is held at zero while the counter is disabled, so the first active tick comes on the eighth edge after the enabling write.
- R9: Control bit 0 enables counting. While it is 0, the count holds its value except when the current-value register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, committed on the rising edge |
| rdEn | input | 1 | Register read strobe; a read of address 0 clears the event flag |
| addr | input | 2 | Register select: 0 control/status, 1 reload, 2 current value |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request, event flag gated by interrupt enable |

## Verification
`rdData` is combinational, so a read shows the state left by the previous rising edge:

- A register write is visible in the very next read.
- The flag clear caused by a status read takes effect on the edge that ends that read.
- With the full clock selected, the count moves one step per edge. After the enabling write it reads 0, then reload, then reload-1 on consecutive reads. The event flag and `irq` appear reload+1 edges after the load point.
- With the divided source, the first load shows up on the ninth read after enabling, and each later step comes eight edges after the one before.

The driver issues each read together with the value expected from this edge count. The monitor samples one time unit after the falling edge that starts the read, which is before the rising edge where the read completes.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int DATA_W = 32;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_SPARE   = 2'd3
  } regAddr_t;

  localparam int BIT_EN      = 0;
  localparam int BIT_IRQEN   = 1;
  localparam int BIT_FULLCLK = 2;
  localparam int BIT_FLAG    = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;      // active tick this cycle
    logic clearCur;  // software write to current value
  } tickStrobe_t;
endpackage

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickStrobe_t      strb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] curCount,
  output logic             hitZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCount <= '0;
    end else if (strb.clearCur) begin
      curCount <= '0;
    end else if (strb.tick) begin
      if (curCount == '0) curCount <= reloadVal;
      else                curCount <= curCount - ONE;
    end
  end

  // 1 -> 0 step on this edge, unless software clears the counter
  assign hitZero = strb.tick && !strb.clearCur && (curCount == ONE);
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DIV   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  curCount,
  input  logic              hitZero,
  output tickStrobe_t       strb,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              enable,
  output logic              fullClk,
  output logic              countFlag
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic irqEn;
  logic divPulse;
  logic ctrlWr, reloadWr, curWr, ctrlRd;
  logic unusedWrBits;

  assign ctrlWr   = wrEn && (addr == REG_CTRL);
  assign reloadWr = wrEn && (addr == REG_RELOAD);
  assign curWr    = wrEn && (addr == REG_CURRENT);
  assign ctrlRd   = rdEn && (addr == REG_CTRL);
  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable    <= 1'b0;
      irqEn     <= 1'b0;
      fullClk   <= 1'b0;
      reloadVal <= '0;
    end else begin
      if (ctrlWr) begin
        enable  <= wrData[BIT_EN];
        irqEn   <= wrData[BIT_IRQEN];
        fullClk <= wrData[BIT_FULLCLK];
      end
      if (reloadWr) reloadVal <= wrData[CNT_W-1:0];
    end
  end

  // event flag: a new event wins over a clear
  always_ff @(posedge clk) begin
    if (!rstN)               countFlag <= 1'b0;
    else if (hitZero)        countFlag <= 1'b1;
    else if (curWr || ctrlRd) countFlag <= 1'b0;
  end

  generate
    if (DIV > 1) begin : g_prescale
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !enable) preCnt <= '0;
        else                  preCnt <= preCnt + 1'b1;
      end
      assign divPulse = (preCnt == PRE_W'(DIV - 1));
    end else begin : g_noprescale
      assign divPulse = 1'b1;
    end
  endgenerate

  assign strb.tick     = enable && (fullClk || divPulse);
  assign strb.clearCur = curWr;

  always_comb begin
    rdData = '0;
    case (addr)
      REG_CTRL: begin
        rdData[BIT_EN]      = enable;
        rdData[BIT_IRQEN]   = irqEn;
        rdData[BIT_FULLCLK] = fullClk;
        rdData[BIT_FLAG]    = countFlag;
      end
      REG_RELOAD:  rdData[CNT_W-1:0] = reloadVal;
      REG_CURRENT: rdData[CNT_W-1:0] = curCount;
      default:     rdData = '0;
    endcase
  end

  assign irq = countFlag && irqEn;
endmodule

// File: rtl/os_tick_timer.sv
module os_tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DIV   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq
);
  tickStrobe_t      strb;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] curCount;
  logic             hitZero;
  logic             enable;
  logic             fullClk;
  logic             countFlag;

  tick_ctrl #(.CNT_W(CNT_W), .DIV(DIV)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .wrData   (wrData),
    .curCount (curCount),
    .hitZero  (hitZero),
    .strb     (strb),
    .reloadVal(reloadVal),
    .rdData   (rdData),
    .irq      (irq),
    .enable   (enable),
    .fullClk  (fullClk),
    .countFlag(countFlag)
  );

  tick_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reloadVal(reloadVal),
    .curCount (curCount),
    .hitZero  (hitZero)
  );
endmodule

// File: rtl/tick_checker.sv
module tick_checker
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic [1:0]       addr,
  input logic             tick,
  input logic             clearCur,
  input logic [CNT_W-1:0] curCount,
  input logic [CNT_W-1:0] reloadVal,
  input logic             countFlag,
  input logic             enable,
  input logic             fullClk
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !clearCur && curCount != '0) |=> curCount == $past(curCount) - ONE); // R2
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !clearCur && curCount == '0) |=> curCount == $past(reloadVal)); // R3
  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !clearCur && curCount == ONE) |=> countFlag); // R4
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == REG_CTRL && !(tick && !clearCur && curCount == ONE)) |=> !countFlag); // R5
  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_CURRENT) |=> (curCount == '0 && !countFlag)); // R6
  AST_ZERO_RELOAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (reloadVal == '0 && curCount == '0 && !(wrEn && addr == REG_RELOAD)) |=> curCount == '0); // R7
  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !fullClk && !(wrEn && addr == REG_CTRL)) |=> !tick); // R8
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !(wrEn && addr == REG_CURRENT)) |=> $stable(curCount)); // R9
endmodule

bind os_tick_timer tick_checker #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addr     (addr),
  .tick     (strb.tick),
  .clearCur (strb.clearCur),
  .curCount (curCount),
  .reloadVal(reloadVal),
  .countFlag(countFlag),
  .enable   (enable),
  .fullClk  (fullClk)
);

// File: tb/test_os_tick_timer.sv
`timescale 1ns/1ps
module test_os_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] val;
    int          irqExp;   // 0, 1, or 2 = do not care
    int          req;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  os_tick_timer i_os_tick_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // monitor: samples after the falling edge that starts a read
  always @(negedge clk) begin
    #1;
    if (rdEn && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      total++;
      if (rdData !== it.val) begin
        bad++;
        $display("FAIL R%0d: addr=%0d rdData=%h expected=%h", it.req, addr, rdData, it.val);
      end
      if (it.irqExp != 2) begin
        total++;
        if (irq !== it.irqExp[0]) begin
          bad++;
          $display("FAIL R%0d: irq=%0b expected=%0d", it.req, irq, it.irqExp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input int irqE, input int req);
    expItem_t it;
    it.val = e; it.irqExp = irqE; it.req = req;
    expQ.push_back(it);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, 32'h0, 0, 1);
    rd(2'd1, 32'h0, 2, 1);
    rd(2'd2, 32'h0, 2, 1);

    // R2 reload width
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h00FF_FFFF, 2, 2);

    // full clock, reload 5, irq enabled: R2 R3 R4 R5
    wr(2'd1, 32'd5);
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h7);
    rd(2'd2, 32'd0, 2, 3);
    rd(2'd2, 32'd5, 2, 3);       // R3 load
    rd(2'd2, 32'd4, 2, 2);       // R2 steps
    rd(2'd2, 32'd3, 2, 2);
    rd(2'd2, 32'd2, 2, 2);
    rd(2'd2, 32'd1, 0, 2);
    rd(2'd0, 32'h0001_0007, 1, 4); // R4 flag and irq
    rd(2'd2, 32'd5, 2, 3);       // R3 reload after zero
    rd(2'd0, 32'h0000_0007, 0, 5); // R5 read cleared flag

    // R4 masked interrupt
    wr(2'd0, 32'h5);
    wr(2'd2, 32'd0);
    idle(6);
    rd(2'd0, 32'h0001_0005, 0, 4);

    // R6 write to current clears count and flag
    wr(2'd2, 32'd0);
    idle(6);
    wr(2'd2, 32'd0);
    rd(2'd0, 32'h0000_0005, 0, 6);
    rd(2'd2, 32'd5, 2, 6);

    // R7 reload zero stays idle
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    idle(20);
    rd(2'd2, 32'd0, 2, 7);
    rd(2'd0, 32'h0000_0005, 0, 7);

    // R8 divided tick source
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd2);
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h3);
    rd(2'd2, 32'd0, 2, 8);
    idle(6);
    rd(2'd2, 32'd0, 2, 8);
    rd(2'd2, 32'd2, 2, 8);
    idle(6);
    rd(2'd2, 32'd2, 2, 8);
    rd(2'd2, 32'd1, 2, 8);
    idle(6);
    rd(2'd0, 32'h0000_0003, 0, 8);
    rd(2'd0, 32'h0001_0003, 1, 8);

    // R9 disable holds the count
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd9);
    wr(2'd0, 32'h5);
    idle(2);
    wr(2'd0, 32'h4);
    idle(10);
    rd(2'd2, 32'd7, 2, 9);

    idle(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule